// File: doc/BRIEF.md
# Word-Stream Memory Command Decoder

This block sits between a host that sends 32-bit command words over a valid/ready word link and a simple synchronous memory port. It parses each incoming stream of words into memory accesses. The top bit of the first word of a command chooses the operation. A write uses that first word for the address and takes a second word as the write data. A read is a single word. For every complete command, the decoder presents an address, write data and a read/write flag, together with an access enable that lasts one clock.

After a read, the memory answers with a valid pulse and the read data. The decoder holds that data on a response port until the host takes it. It never sends a word for a write. While a command is being issued or its response is outstanding, the command input is closed.

The parser walks five named states. IDLE waits for a first word: bit 31 = 0 goes to WAIT_DATA, and bit 31 = 1 goes to ISSUE. WAIT_DATA takes the write data word and goes to ISSUE. ISSUE drives the access enable for one cycle, then returns to IDLE for a write or moves to WAIT_RDATA for a read. WAIT_RDATA goes to RESPOND when the memory signals valid read data. RESPOND holds the response word and returns to IDLE once the host accepts it.

Top module: `memcmd_decoder`

## Requirements
- R1: Bit 31 of a command's first word selects the operation: 0 is a write and 1 is a read. During the access strobe, `mem_we` is 1 for a write and 0 for a read.
- R2: During the access strobe, `mem_addr` equals the low ADDR_W bits (ADDR_W at most 31) of the command's first word.
- R3: A write takes exactly two accepted words. During its strobe, `mem_wdata` equals the low DATA_W bits of the second word.
- R4: The access strobe comes in the cycle right after the last word of a command is accepted: the second word of a write, or the only word of a read.
- R5: `mem_en` is high for exactly one clock per command and never for two clocks in a row.
- R6: `cmd_ready` is high only in IDLE and WAIT_DATA. After a write strobe it returns high in the next cycle. After a read it stays low until the response has been taken.
- R7: For a read, the `mem_rdata` value seen with `mem_rvalid` in WAIT_RDATA appears on `rsp_word`, zero-extended above DATA_W, with `rsp_valid` high in the next cycle. Both are held unchanged until `rsp_ready` is seen high.
- R8: `rsp_valid` is never raised for a write or while no read is outstanding.
- R9: A `mem_rvalid` pulse that arrives while no read is waiting for data is ignored. No response is produced, and the next read returns its own data.
- R10: A synchronous `rst` returns the parser to IDLE. In the following cycle, `cmd_ready` = 1, `mem_en` = 0 and `rsp_valid` = 0. A partly received write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command word valid |
| cmd_ready | output | 1 | Decoder accepts a command word |
| cmd_word | input | 32 | Host command word |
| rsp_valid | output | 1 | Read response word valid |
| rsp_ready | input | 1 | Host takes the response word |
| rsp_word | output | 32 | Read response data, zero-extended |
| mem_en | output | 1 | One-cycle access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The hardest states to reach from the ports are a read response held under host back-pressure while a new command word is already waiting at the input, and a reset that lands between the two words of a write. The stimulus stalls `rsp_ready` for a programmed number of cycles and keeps host words queued with `cmd_valid` high during that stall. It also pulses reset after only the address word of a write has been accepted, then issues a read to show that the dropped data word is not consumed. A stray memory-valid pulse is injected in IDLE to show that it is ignored.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

    localparam int WORD_W = 32;
    localparam int OP_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_DATA  = 3'd1,
        ST_ISSUE      = 3'd2,
        ST_WAIT_RDATA = 3'd3,
        ST_RESPOND    = 3'd4
    } parse_state_t;

endpackage

// File: rtl/memcmd_word_split.sv
module memcmd_word_split
    import memcmd_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int DATA_W = 32
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_read,
    output logic [ADDR_W-1:0] addr_field,
    output logic [DATA_W-1:0] data_field
);

    // Operation flag sits in the top bit; address and data fill from bit 0.
    always_comb begin
        is_read    = word[OP_BIT];
        addr_field = word[ADDR_W-1:0];
        data_field = word[DATA_W-1:0];
    end

endmodule

// File: rtl/memcmd_hold_reg.sv
module memcmd_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/memcmd_fsm.sv
module memcmd_fsm
    import memcmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         word_valid,
    input  logic         word_is_read,
    input  logic         pend_write,
    input  logic         rd_valid,
    input  logic         rsp_take,
    output parse_state_t state,
    output logic         ready,
    output logic         strobe,
    output logic         take_first,
    output logic         take_second,
    output logic         take_rsp,
    output logic         rsp_pending
);

    parse_state_t nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (word_valid) begin
                    nxt = word_is_read ? ST_ISSUE : ST_WAIT_DATA;
                end
            end
            ST_WAIT_DATA: begin
                if (word_valid) begin
                    nxt = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                nxt = pend_write ? ST_IDLE : ST_WAIT_RDATA;
            end
            ST_WAIT_RDATA: begin
                if (rd_valid) begin
                    nxt = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                if (rsp_take) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        ready       = 1'b0;
        strobe      = 1'b0;
        take_first  = 1'b0;
        take_second = 1'b0;
        take_rsp    = 1'b0;
        rsp_pending = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready      = 1'b1;
                take_first = word_valid;
            end
            ST_WAIT_DATA: begin
                ready       = 1'b1;
                take_second = word_valid;
            end
            ST_ISSUE: begin
                strobe = 1'b1;
            end
            ST_WAIT_RDATA: begin
                take_rsp = rd_valid;
            end
            ST_RESPOND: begin
                rsp_pending = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/memcmd_decoder.sv
module memcmd_decoder
    import memcmd_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_word,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_word,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int PAD_W = WORD_W - DATA_W;

    parse_state_t st;
    logic              w_is_read;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              take_first;
    logic              take_second;
    logic              take_rsp;
    logic              we_q;
    logic [WORD_W-1:0] rdata_ext;

    memcmd_word_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_split (
        .word       (cmd_word),
        .is_read    (w_is_read),
        .addr_field (w_addr),
        .data_field (w_data)
    );

    memcmd_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .word_valid   (cmd_valid),
        .word_is_read (w_is_read),
        .pend_write   (we_q),
        .rd_valid     (mem_rvalid),
        .rsp_take     (rsp_ready),
        .state        (st),
        .ready        (cmd_ready),
        .strobe       (mem_en),
        .take_first   (take_first),
        .take_second  (take_second),
        .take_rsp     (take_rsp),
        .rsp_pending  (rsp_valid)
    );

    memcmd_hold_reg #(.W(1)) u_we (
        .clk(clk), .rst(rst), .load(take_first), .d(~w_is_read), .q(we_q)
    );

    memcmd_hold_reg #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(take_first), .d(w_addr), .q(mem_addr)
    );

    memcmd_hold_reg #(.W(DATA_W)) u_wdata (
        .clk(clk), .rst(rst), .load(take_second), .d(w_data), .q(mem_wdata)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata_ext = {{PAD_W{1'b0}}, mem_rdata};
        end else begin : g_full
            assign rdata_ext = mem_rdata;
        end
    endgenerate

    memcmd_hold_reg #(.W(WORD_W)) u_rsp (
        .clk(clk), .rst(rst), .load(take_rsp), .d(rdata_ext), .q(rsp_word)
    );

    assign mem_we = we_q;

endmodule

// File: rtl/memcmd_decoder_chk.sv
module memcmd_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_word,
    input logic        mem_en,
    input logic        mem_we,
    input logic        mem_rvalid
);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> !mem_en);

    // R6
    ready_resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && (rsp_valid || mem_en)));

    // R6
    write_reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |=> cmd_ready);

    // R7
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word)));

    // R8
    rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(mem_rvalid));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cmd_ready && !mem_en && !rsp_valid));

endmodule

bind memcmd_decoder memcmd_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_word   (rsp_word),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid)
);

// File: tb/tb_memcmd_decoder.sv
`timescale 1ns/1ps
module tb_memcmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_word;
    logic        mem_en;
    logic        mem_we;
    logic [30:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    memcmd_decoder dut (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // host and memory models
    logic [31:0] hq[$];
    logic [31:0] got[$];
    logic [31:0] mem_store[logic [30:0]];
    int host_gap = 0;
    int gap_cnt = 0;
    int stall_cnt = 0;
    int rd_lat = 1;
    int rd_cnt = 0;
    logic [31:0] rd_val;
    bit stray = 0;

    // reference: 0 idle, 1 need data, 2 access, 3 wait memory, 4 respond
    int ph = 0;
    logic [30:0] m_addr;
    logic        m_we;
    logic [31:0] m_wdata;
    logic [31:0] m_rsp;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0;
        end else begin
            case (ph)
                0: if (cmd_valid) begin
                    void'(hq.pop_front());
                    gap_cnt = host_gap;
                    m_addr = cmd_word[30:0];
                    m_we = !cmd_word[31];
                    ph = cmd_word[31] ? 2 : 1;
                end
                1: if (cmd_valid) begin
                    void'(hq.pop_front());
                    gap_cnt = host_gap;
                    m_wdata = cmd_word;
                    ph = 2;
                end
                2: ph = m_we ? 0 : 3;
                3: if (mem_rvalid) begin
                    m_rsp = mem_rdata;
                    ph = 4;
                end
                4: if (rsp_ready) begin
                    got.push_back(rsp_word);
                    ph = 0;
                end
                default: ph = 0;
            endcase
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] lookup(logic [30:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return {1'b0, a} * 32'h9E37 ^ 32'h5A5A_5A5A;
    endfunction

    task automatic compare();
        chk(cmd_ready == (ph <= 1), "R6 ready", {31'd0, cmd_ready}, {31'd0, ph <= 1});
        chk(mem_en == (ph == 2), "R4 R5 strobe", {31'd0, mem_en}, {31'd0, ph == 2});
        chk(rsp_valid == (ph == 4), (ph == 4) ? "R7 rsp_valid" : "R8 rsp_valid",
            {31'd0, rsp_valid}, {31'd0, ph == 4});
        if (ph == 2) begin
            chk(mem_we == m_we, "R1 op", {31'd0, mem_we}, {31'd0, m_we});
            chk(mem_addr == m_addr, "R2 addr", {1'b0, mem_addr}, {1'b0, m_addr});
            if (m_we) chk(mem_wdata == m_wdata, "R3 wdata", mem_wdata, m_wdata);
        end
        if (ph == 4) chk(rsp_word == m_rsp, "R7 rsp_word", rsp_word, m_rsp);
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        compare();
        mem_rvalid = 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = rd_val;
            end
        end
        if (!rst && mem_en) begin
            if (mem_we) mem_store[mem_addr] = mem_wdata;
            else begin
                rd_cnt = rd_lat;
                rd_val = lookup(mem_addr);
            end
        end
        if (stray) begin
            mem_rvalid = 1'b1;
            mem_rdata = 32'hBAD0_BAD0;
            stray = 0;
        end
        if (gap_cnt > 0) begin
            gap_cnt--;
            cmd_valid = 1'b0;
            cmd_word = '0;
        end else if (hq.size() > 0) begin
            cmd_valid = 1'b1;
            cmd_word = hq[0];
        end else begin
            cmd_valid = 1'b0;
            cmd_word = '0;
        end
        rsp_ready = (stall_cnt == 0);
        if (stall_cnt > 0 && rsp_valid) stall_cnt--;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            if (hq.size() == 0 && ph == 0 && rd_cnt == 0 && !cmd_valid) break;
            step();
        end
        step();
    endtask

    task automatic put_write(logic [30:0] a, logic [31:0] d);
        hq.push_back({1'b0, a});
        hq.push_back(d);
    endtask

    task automatic put_read(logic [30:0] a);
        hq.push_back({1'b1, a});
    endtask

    task automatic expect_rsp(logic [31:0] e, string tag);
        logic [31:0] v;
        v = (got.size() > 0) ? got.pop_front() : 32'hXXXX_XXXX;
        chk(v === e, tag, v, e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rd_cnt = 0;
        hq.delete();
        step();
        step();
        rst = 1'b0;
        gap_cnt = 0;
        step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        step();
        step();
        rst = 1'b0;
        step();
        // R10 state after reset
        chk(cmd_ready === 1'b1, "R10 ready after reset", {31'd0, cmd_ready}, 32'd1);
        chk(mem_en === 1'b0 && rsp_valid === 1'b0, "R10 idle outputs",
            {30'd0, mem_en, rsp_valid}, 32'd0);

        // back-to-back write then read
        put_write(31'h10, 32'hDEAD_BEEF);
        put_read(31'h10);
        wait_idle();
        expect_rsp(32'hDEAD_BEEF, "R7 readback after R3 write");
        chk(got.size() == 0, "R8 no response for write", got.size(), 0);

        // gapped words, top address, stalled response
        host_gap = 3;
        put_write(31'h7FFF_FFFF, 32'h0000_1234);
        stall_cnt = 5;
        rd_lat = 3;
        put_read(31'h7FFF_FFFF);
        put_read(31'h0000_0020);
        wait_idle();
        expect_rsp(32'h0000_1234, "R2 R7 top address readback");
        expect_rsp(lookup(31'h20), "R7 unwritten address");
        host_gap = 0;
        rd_lat = 1;

        // stray memory valid in idle
        stray = 1;
        step();
        step();
        step();
        chk(rsp_valid === 1'b0, "R9 stray rvalid ignored", {31'd0, rsp_valid}, 0);
        chk(got.size() == 0, "R9 no response queued", got.size(), 0);
        put_read(31'h10);
        wait_idle();
        expect_rsp(32'hDEAD_BEEF, "R9 next read own data");

        // mixed traffic
        for (int k = 0; k < 40; k++) begin
            logic [30:0] a;
            a = 31'($urandom % 12);
            if ($urandom % 2 == 1) put_read(a);
            else put_write(a, $urandom);
        end
        stall_cnt = 2;
        rd_lat = 2;
        wait_idle();
        got.delete();
        for (int k = 0; k < 30; k++) begin
            host_gap = $urandom % 3;
            rd_lat = 1 + $urandom % 3;
            stall_cnt = $urandom % 4;
            if ($urandom % 2 == 1) put_read(31'($urandom % 12));
            else put_write(31'($urandom % 12), $urandom);
            wait_idle();
        end
        got.delete();
        host_gap = 0;
        rd_lat = 1;

        // reset between the two words of a write
        hq.push_back({1'b0, 31'h33});
        for (int i = 0; i < 5 && ph != 1; i++) step();
        do_reset();
        chk(cmd_ready === 1'b1, "R10 ready after mid-write reset", {31'd0, cmd_ready}, 1);
        chk(mem_en === 1'b0, "R10 no strobe after reset", {31'd0, mem_en}, 0);
        put_read(31'h10);
        wait_idle();
        expect_rsp(32'hDEAD_BEEF, "R10 read after dropped write");

        // reset while response held
        stall_cnt = 50;
        put_read(31'h10);
        for (int i = 0; i < 20 && !rsp_valid; i++) step();
        chk(rsp_valid === 1'b1, "R7 response pending", {31'd0, rsp_valid}, 1);
        stall_cnt = 0;
        do_reset();
        chk(rsp_valid === 1'b0, "R10 response cleared", {31'd0, rsp_valid}, 0);
        wait_idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule